// File: doc/BRIEF.md
# Nesting Priority Interrupt Controller

This block arbitrates up to 32 interrupt sources for an instruction sequencer. It keeps three state words: a latch of pending requests, a mask of enabled requests, and a service-pointer word that records which routines have been entered and are still open. On each cycle it picks the highest-priority request that is allowed to run. It then issues a one-cycle request pulse to the sequencer. The pulse carries the source index, its vector address in the chosen table, and a flag that tells the sequencer whether to save the status context.

External request lines pass through one synchronizing flop and can be edge- or level-sensitive. A timer expiry lights two sources at once, so software chooses the timer priority by enabling one of them. The sequencer reports when a routine finishes (return) or when a routine asks to drop its own in-service mark early (clear-current). The sequencer can also hold off issuing while a branch is under way; a held request stays pending.

Top module: `icu_nest_ctrl`

## Requirements
- R1: Priority falls with index: index 0 is the highest and index 31 the lowest. Of the requests that are allowed to issue, the lowest-indexed one is taken.
- R2: The vector equals the table base plus four times the index. The base is 0x00020000 when `ext_table_i` is 0 and 0x00400000 when it is 1.
- R3: A request issues only while `gie_i` is 1 and its mask bit is 1. A masked request stays set in the latch and issues once it is unmasked.
- R4: Index 1 is the reset source and issues whatever its mask bit holds.
- R5: Issuing source k sets pointer bit k. When the pointer is non-zero and `nest_en_i` is 1, only indices below the lowest set pointer bit may issue.
- R6: When the pointer is non-zero and `nest_en_i` is 0, nothing issues.
- R7: A return clears the lowest set pointer bit and the matching latch bit. When that index is in the context class (R9), `stat_pop_o` pulses after the edge.
- R8: While pointer bit k is set, latch bit k is held at 0 and new events on k are dropped. Clear-current clears the lowest set pointer bit, which ends this clearing, and raises `stat_pop_o` for context-class indices.
- R9: `stat_push_o` is 1 with an issued request exactly when the index is 4, 5, 6, 7, 8 or 23.
- R10: A `timer_zero_i` pulse sets latch bits 4 and 23 together.
- R11: After reset the latch, the pointer and `irq_valid_o` are 0. The mask is 0, except that bit 16 is 1 when `boot_mode_i` is 1 during reset.
- R12: External line i drives latch bit 6+i. A pin sampled at edge k appears in the latch after edge k+1 and issues after edge k+2. In edge mode (`ext_edge_i` bit = 1) a pin held high raises the request only once; in level mode it raises it again on every cycle that its pointer bit is clear. A software latch write issues after the next edge.
- R13: While `hold_i` is 1 nothing issues, and the pending request stays latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_mode_i | input | 1 | Sampled during reset to preset mask bit 16 |
| ext_pin_i | input | N_EXT | Raw external request lines |
| ext_edge_i | input | N_EXT | Per line: 1 = edge-sensitive, 0 = level-sensitive |
| timer_zero_i | input | 1 | Timer expiry pulse |
| vec_irq_i | input | 1 | Vector interrupt pulse (source 5) |
| wr_latch_en_i | input | 1 | Write `wr_data_i` into the latch |
| wr_mask_en_i | input | 1 | Write `wr_data_i` into the mask |
| wr_ptr_en_i | input | 1 | Write `wr_data_i` into the service pointer |
| wr_data_i | input | 32 | Software write data |
| gie_i | input | 1 | Global interrupt enable |
| nest_en_i | input | 1 | Nesting mode enable |
| ext_table_i | input | 1 | Vector table select |
| hold_i | input | 1 | Sequencer hold-off |
| rti_i | input | 1 | Return-from-interrupt strobe |
| clr_cur_i | input | 1 | Clear-current-interrupt strobe |
| irq_valid_o | output | 1 | One-cycle request pulse |
| irq_vec_o | output | ADDR_W | Vector address |
| irq_idx_o | output | 5 | Source index |
| stat_push_o | output | 1 | Status context must be pushed |
| stat_pop_o | output | 1 | Status context must be popped |
| latch_o | output | 32 | Latch state |
| mask_o | output | 32 | Mask state |
| ptr_o | output | 32 | Service pointer state |

## Verification
The assertions assume two things about the sequencer: return and clear-current are strobed only while at least one routine is open, and the pointer is never written in the cycle a request issues. The stimulus follows both. Every return or clear-current is issued after a matching entry, and pointer writes are never driven. Event pulses on the timer and external lines are applied only while gie, mask and nesting settings are steady, so each expected entry cycle follows from the latch timing in R12.

// File: rtl/icu_pkg.sv
package icu_pkg;
  localparam int unsigned NSRC  = 32;
  localparam int unsigned IDX_W = $clog2(NSRC);

  // Fixed source positions; the priority decode depends on them.
  localparam int unsigned SRC_RESET   = 1;
  localparam int unsigned SRC_TMR_HI  = 4;
  localparam int unsigned SRC_VEC     = 5;
  localparam int unsigned SRC_EXT0    = 6;
  localparam int unsigned SRC_BOOTMSK = 16;
  localparam int unsigned SRC_TMR_LO  = 23;
  localparam int unsigned CTX_EXTS    = 3;

  typedef logic [NSRC-1:0]  src_vec_t;
  typedef logic [IDX_W-1:0] src_idx_t;

  // Lowest set index = highest priority.
  function automatic src_idx_t first_set(input src_vec_t v);
    src_idx_t r;
    r = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (v[i]) r = src_idx_t'(i);
    return r;
  endfunction

  // Sources whose entry saves the status context.
  function automatic logic needs_ctx(input src_idx_t k);
    int unsigned u;
    u = int'(k);
    return (u == SRC_TMR_HI) || (u == SRC_VEC) || (u == SRC_TMR_LO) ||
           (u >= SRC_EXT0 && u < SRC_EXT0 + CTX_EXTS);
  endfunction
endpackage

// File: rtl/icu_ext_sync.sv
module icu_ext_sync #(
  parameter int unsigned N_EXT = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_EXT-1:0] pin_i,
  input  logic [N_EXT-1:0] edge_mode_i,
  output logic [N_EXT-1:0] req_o
);
  logic [N_EXT-1:0] smp_q;
  logic [N_EXT-1:0] prv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_q <= '0;
      prv_q <= '0;
    end else begin
      smp_q <= pin_i;
      prv_q <= smp_q;
    end
  end

  for (genvar g = 0; g < N_EXT; g++) begin : g_line
    assign req_o[g] = edge_mode_i[g] ? (smp_q[g] & ~prv_q[g]) : smp_q[g];
  end
endmodule

// File: rtl/icu_prio.sv
module icu_prio
  import icu_pkg::*;
(
  input  src_vec_t latch_i,
  input  src_vec_t mask_i,
  input  src_vec_t ptr_i,
  input  logic     gie_i,
  input  logic     nest_en_i,
  output logic     found_o,
  output src_idx_t idx_o
);
  src_vec_t allow;
  src_vec_t cand;
  src_idx_t top;

  always_comb begin
    top = first_set(ptr_i);
    for (int i = 0; i < NSRC; i++) begin
      if (ptr_i == '0) allow[i] = 1'b1;
      else             allow[i] = nest_en_i && (i < int'(top));
    end
    cand = latch_i & (mask_i | (src_vec_t'(1) << SRC_RESET)) & allow
         & {NSRC{gie_i}};
    found_o = |cand;
    idx_o   = first_set(cand);
  end
endmodule

// File: rtl/icu_nest_ctrl.sv
module icu_nest_ctrl
  import icu_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] INT_BASE = 32'h0002_0000,
  parameter logic [ADDR_W-1:0] EXT_BASE = 32'h0040_0000,
  parameter int unsigned VEC_SHIFT = 2,
  parameter int unsigned N_EXT     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              boot_mode_i,
  input  logic [N_EXT-1:0]  ext_pin_i,
  input  logic [N_EXT-1:0]  ext_edge_i,
  input  logic              timer_zero_i,
  input  logic              vec_irq_i,
  input  logic              wr_latch_en_i,
  input  logic              wr_mask_en_i,
  input  logic              wr_ptr_en_i,
  input  logic [NSRC-1:0]   wr_data_i,
  input  logic              gie_i,
  input  logic              nest_en_i,
  input  logic              ext_table_i,
  input  logic              hold_i,
  input  logic              rti_i,
  input  logic              clr_cur_i,
  output logic              irq_valid_o,
  output logic [ADDR_W-1:0] irq_vec_o,
  output logic [IDX_W-1:0]  irq_idx_o,
  output logic              stat_push_o,
  output logic              stat_pop_o,
  output logic [NSRC-1:0]   latch_o,
  output logic [NSRC-1:0]   mask_o,
  output logic [NSRC-1:0]   ptr_o
);
  src_vec_t latch_q, mask_q, ptr_q;
  src_vec_t latch_d, ptr_d, sets;
  logic [N_EXT-1:0] ext_req;
  logic     found, entry, retire;
  src_idx_t sel_idx, top_idx;
  logic     valid_q, push_q, pop_q;
  src_idx_t idx_q;
  logic [ADDR_W-1:0] vec_q;

  icu_ext_sync #(.N_EXT(N_EXT)) u_sync (
    .clk(clk), .rst(rst), .pin_i(ext_pin_i),
    .edge_mode_i(ext_edge_i), .req_o(ext_req)
  );

  icu_prio u_prio (
    .latch_i(latch_q), .mask_i(mask_q), .ptr_i(ptr_q),
    .gie_i(gie_i), .nest_en_i(nest_en_i),
    .found_o(found), .idx_o(sel_idx)
  );

  assign entry   = found & ~hold_i;
  assign retire  = (rti_i | clr_cur_i) & (|ptr_q);
  assign top_idx = first_set(ptr_q);

  always_comb begin
    sets = '0;
    for (int i = 0; i < int'(N_EXT); i++) sets[SRC_EXT0 + i] = ext_req[i];
    sets[SRC_TMR_HI] = timer_zero_i;
    sets[SRC_TMR_LO] = timer_zero_i;
    sets[SRC_VEC]    = vec_irq_i;

    latch_d = wr_latch_en_i ? wr_data_i : latch_q;
    latch_d = (latch_d | sets) & ~ptr_q;
    if (entry) latch_d[sel_idx] = 1'b0;

    ptr_d = wr_ptr_en_i ? wr_data_i : ptr_q;
    if (retire) ptr_d[top_idx] = 1'b0;
    if (entry)  ptr_d[sel_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
      mask_q  <= boot_mode_i ? (src_vec_t'(1) << SRC_BOOTMSK) : '0;
      ptr_q   <= '0;
      valid_q <= 1'b0;
      push_q  <= 1'b0;
      pop_q   <= 1'b0;
      idx_q   <= '0;
      vec_q   <= '0;
    end else begin
      latch_q <= latch_d;
      ptr_q   <= ptr_d;
      if (wr_mask_en_i) mask_q <= wr_data_i;
      valid_q <= entry;
      pop_q   <= retire & needs_ctx(top_idx);
      if (entry) begin
        idx_q  <= sel_idx;
        push_q <= needs_ctx(sel_idx);
        vec_q  <= (ext_table_i ? EXT_BASE : INT_BASE)
                + (ADDR_W'(sel_idx) << VEC_SHIFT);
      end
    end
  end

  assign irq_valid_o = valid_q;
  assign irq_vec_o   = vec_q;
  assign irq_idx_o   = idx_q;
  assign stat_push_o = push_q & valid_q;
  assign stat_pop_o  = pop_q;
  assign latch_o     = latch_q;
  assign mask_o      = mask_q;
  assign ptr_o       = ptr_q;
endmodule

// File: rtl/icu_nest_ctrl_chk.sv
module icu_nest_ctrl_chk
  import icu_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter logic [ADDR_W-1:0] INT_BASE = 32'h0002_0000,
  parameter logic [ADDR_W-1:0] EXT_BASE = 32'h0040_0000,
  parameter int unsigned VEC_SHIFT = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              ext_table_i,
  input logic              gie_i,
  input logic              nest_en_i,
  input logic              hold_i,
  input logic              wr_ptr_en_i,
  input logic              irq_valid_o,
  input logic [ADDR_W-1:0] irq_vec_o,
  input logic [IDX_W-1:0]  irq_idx_o,
  input logic              stat_push_o,
  input logic [NSRC-1:0]   latch_o,
  input logic [NSRC-1:0]   ptr_o
);
  a_r2_vector_addr: assert property (@(posedge clk) disable iff (rst)
    irq_valid_o |-> irq_vec_o == (($past(ext_table_i) ? EXT_BASE : INT_BASE)
                                  + (ADDR_W'(irq_idx_o) << VEC_SHIFT)));

  a_r3_gie_blocks: assert property (@(posedge clk) disable iff (rst)
    !gie_i |=> !irq_valid_o);

  a_r5_entry_marks_ptr: assert property (@(posedge clk) disable iff (rst)
    (irq_valid_o && !$past(wr_ptr_en_i)) |-> ptr_o[irq_idx_o]);

  a_r6_nonnest_blocks: assert property (@(posedge clk) disable iff (rst)
    ((|ptr_o) && !nest_en_i) |=> !irq_valid_o);

  a_r8_latch_cleared: assert property (@(posedge clk) disable iff (rst)
    irq_valid_o |-> !latch_o[irq_idx_o]);

  a_r9_ctx_class: assert property (@(posedge clk) disable iff (rst)
    irq_valid_o |-> stat_push_o == (irq_idx_o == 5'd4 || irq_idx_o == 5'd5 ||
      irq_idx_o == 5'd6 || irq_idx_o == 5'd7 || irq_idx_o == 5'd8 ||
      irq_idx_o == 5'd23));

  a_r13_hold_blocks: assert property (@(posedge clk) disable iff (rst)
    hold_i |=> !irq_valid_o);
endmodule

bind icu_nest_ctrl icu_nest_ctrl_chk #(
  .ADDR_W(ADDR_W), .INT_BASE(INT_BASE), .EXT_BASE(EXT_BASE),
  .VEC_SHIFT(VEC_SHIFT)
) u_chk (
  .clk(clk), .rst(rst), .ext_table_i(ext_table_i), .gie_i(gie_i),
  .nest_en_i(nest_en_i), .hold_i(hold_i), .wr_ptr_en_i(wr_ptr_en_i),
  .irq_valid_o(irq_valid_o), .irq_vec_o(irq_vec_o), .irq_idx_o(irq_idx_o),
  .stat_push_o(stat_push_o), .latch_o(latch_o), .ptr_o(ptr_o)
);

// File: tb/icu_nest_ctrl_test.sv
module icu_nest_ctrl_test;
  localparam int CLK_P = 10;
  localparam int NROW  = 36;

  // Row: {ctl[7:0], data[31:0], exp_valid, exp_idx[4:0]}
  // ctl = {wr_latch, wr_mask, wr_ptr, rti, clr_cur, gie, nest, hold}
  localparam logic [45:0] ROWS [NROW] = '{
    {8'h46, 32'hFFFF_FFFF, 1'b0, 5'd0},   // R3 enable all
    {8'h86, 32'h4000_0000, 1'b0, 5'd0},   // R12 sw write
    {8'h06, 32'h0,         1'b1, 5'd30},  // R12 issues next cycle
    {8'h06, 32'h0,         1'b0, 5'd0},
    {8'h86, 32'h2000_0400, 1'b0, 5'd0},
    {8'h06, 32'h0,         1'b1, 5'd10},  // R1 lower index wins, R5 nest
    {8'h06, 32'h0,         1'b0, 5'd0},   // R5 29 blocked by 10
    {8'h16, 32'h0,         1'b0, 5'd0},   // R7 return
    {8'h06, 32'h0,         1'b1, 5'd29},
    {8'h16, 32'h0,         1'b0, 5'd0},
    {8'h16, 32'h0,         1'b0, 5'd0},
    {8'h86, 32'h8000_0000, 1'b0, 5'd0},
    {8'h06, 32'h0,         1'b1, 5'd31},
    {8'h84, 32'h0000_0004, 1'b0, 5'd0},
    {8'h04, 32'h0,         1'b0, 5'd0},   // R6 nesting off blocks
    {8'h06, 32'h0,         1'b1, 5'd2},
    {8'h16, 32'h0,         1'b0, 5'd0},
    {8'h16, 32'h0,         1'b0, 5'd0},
    {8'h46, 32'hEFFF_FFFF, 1'b0, 5'd0},
    {8'h86, 32'h1000_0000, 1'b0, 5'd0},
    {8'h06, 32'h0,         1'b0, 5'd0},   // R3 masked
    {8'h46, 32'hFFFF_FFFF, 1'b0, 5'd0},
    {8'h06, 32'h0,         1'b1, 5'd28},  // R3 kept latched
    {8'h0E, 32'h0,         1'b0, 5'd0},
    {8'h82, 32'h2000_0000, 1'b0, 5'd0},
    {8'h02, 32'h0,         1'b0, 5'd0},   // R3 gie off
    {8'h06, 32'h0,         1'b1, 5'd29},
    {8'h16, 32'h0,         1'b0, 5'd0},
    {8'h86, 32'h0000_0008, 1'b0, 5'd0},
    {8'h07, 32'h0,         1'b0, 5'd0},   // R13 hold
    {8'h06, 32'h0,         1'b1, 5'd3},   // R13 not dropped
    {8'h16, 32'h0,         1'b0, 5'd0},
    {8'h46, 32'h0,         1'b0, 5'd0},
    {8'h86, 32'h0000_0002, 1'b0, 5'd0},
    {8'h06, 32'h0,         1'b1, 5'd1},   // R4 reset source ignores mask
    {8'h16, 32'h0,         1'b0, 5'd0}
  };
  localparam int ROW_REQ [NROW] = '{3,12,12,12,1,1,5,7,5,7,7,6,6,6,6,5,7,7,
                                    3,3,3,3,3,7,3,3,3,7,13,13,13,7,4,4,4,7};

  logic clk = 1'b0, rst = 1'b1, boot = 1'b0;
  logic [2:0] ext_pin = '0, ext_edge = '1;
  logic timer = 1'b0, vec_irq = 1'b0;
  logic wl = 0, wm = 0, wp = 0, rti = 0, clr = 0, gie = 0, nest = 0, hold = 0;
  logic [31:0] wdata = '0;
  logic ext_tab = 1'b0;
  logic        irq_valid, push, pop;
  logic [31:0] vec, latch, mask, ptr;
  logic [4:0]  idx;
  int n_chk = 0, n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  icu_nest_ctrl uut (
    .clk(clk), .rst(rst), .boot_mode_i(boot), .ext_pin_i(ext_pin),
    .ext_edge_i(ext_edge), .timer_zero_i(timer), .vec_irq_i(vec_irq),
    .wr_latch_en_i(wl), .wr_mask_en_i(wm), .wr_ptr_en_i(wp),
    .wr_data_i(wdata), .gie_i(gie), .nest_en_i(nest),
    .ext_table_i(ext_tab), .hold_i(hold), .rti_i(rti), .clr_cur_i(clr),
    .irq_valid_o(irq_valid), .irq_vec_o(vec), .irq_idx_o(idx),
    .stat_push_o(push), .stat_pop_o(pop), .latch_o(latch),
    .mask_o(mask), .ptr_o(ptr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] c, input logic [31:0] d);
    {wl, wm, wp, rti, clr, gie, nest, hold} = c;
    wdata = d;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 20000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    tick(); tick();
    rst = 1'b0;
    #1;
    chk("R11 latch after reset", latch, 32'h0);
    chk("R11 mask after reset", mask, 32'h0);
    chk("R11 ptr after reset", ptr, 32'h0);
    chk("R11 valid after reset", {31'h0, irq_valid}, 32'h0);

    for (int r = 0; r < NROW; r++) begin
      logic [7:0] c; logic [31:0] d; logic ev; logic [4:0] ei;
      {c, d, ev, ei} = ROWS[r];
      drive(c, d);
      tick();
      chk($sformatf("R%0d row %0d valid", ROW_REQ[r], r), {31'h0, irq_valid}, {31'h0, ev});
      if (ev) chk($sformatf("R%0d row %0d index", ROW_REQ[r], r), {27'h0, idx}, {27'h0, ei});
    end

    // Timer: R10, R2, R9, R8, R7
    drive(8'h46, 32'h0080_0000); tick();
    drive(8'h06, 32'h0); timer = 1'b1; tick(); timer = 1'b0;
    chk("R10 timer sets 4 and 23", latch, 32'h0080_0010);
    tick();
    chk("R10 timer low issues", {31'h0, irq_valid}, 32'h1);
    chk("R10 index", {27'h0, idx}, 32'd23);
    chk("R2 internal vector", vec, 32'h0002_005C);
    chk("R9 push for timer", {31'h0, push}, 32'h1);
    chk("R3 masked bit 4 kept", latch, 32'h0000_0010);
    timer = 1'b1; tick(); timer = 1'b0;
    chk("R8 event dropped in service", latch, 32'h0000_0010);
    drive(8'h0E, 32'h0); tick(); drive(8'h06, 32'h0);
    chk("R8 clear-current pop", {31'h0, pop}, 32'h1);
    chk("R8 clear-current ptr", ptr, 32'h0);
    timer = 1'b1; tick(); timer = 1'b0;
    chk("R8 latching resumes", latch, 32'h0080_0010);
    tick();
    chk("R8 re-entry", {27'h0, idx, irq_valid}, {27'd23, 1'b1});
    drive(8'h16, 32'h0); tick(); drive(8'h06, 32'h0);
    chk("R7 return pop", {31'h0, pop}, 32'h1);
    chk("R7 return ptr", ptr, 32'h0);
    chk("R7 return latch", latch, 32'h0000_0010);
    drive(8'h86, 32'h0); tick();

    // External edge line 1 -> source 7: R12, R2, R9
    drive(8'h46, 32'h0000_0080); tick();
    drive(8'h06, 32'h0); ext_tab = 1'b1; ext_edge = 3'b111;
    ext_pin = 3'b010; tick();
    chk("R12 not latched after sync edge", latch, 32'h0);
    tick();
    chk("R12 latched one cycle later", latch, 32'h0000_0080);
    chk("R12 not yet issued", {31'h0, irq_valid}, 32'h0);
    tick();
    chk("R12 issued", {27'h0, idx, irq_valid}, {27'd7, 1'b1});
    chk("R2 external vector", vec, 32'h0040_001C);
    chk("R9 push for external", {31'h0, push}, 32'h1);
    drive(8'h16, 32'h0); tick(); drive(8'h06, 32'h0);
    tick(); tick();
    chk("R12 edge mode no retrigger", latch, 32'h0);
    ext_pin = 3'b000;

    // External level line 0 -> source 6: R12
    drive(8'h46, 32'h0000_0040); tick();
    drive(8'h06, 32'h0); ext_edge = 3'b110; ext_pin = 3'b001;
    tick(); tick(); tick();
    chk("R12 level issued", {27'h0, idx, irq_valid}, {27'd6, 1'b1});
    drive(8'h16, 32'h0); tick(); drive(8'h06, 32'h0); tick();
    chk("R12 level relatch", latch, 32'h0000_0040);
    ext_pin = 3'b000; drive(8'h82, 32'h0); tick(); tick();

    // Boot-mode reset: R11
    rst = 1'b1; boot = 1'b1; tick(); tick(); rst = 1'b0; boot = 1'b0;
    #1;
    chk("R11 boot mask", mask, 32'h0001_0000);
    chk("R11 boot latch", latch, 32'h0);
    summary();
  end
endmodule